// File: doc/BRIEF.md
# Directory RAM Maintenance and Fault-Injection Port

This block holds a small directory RAM of 133-bit entries and gives software a register window for inspecting and altering them. Each entry carries 125 data bits and 8 check bits in its upper end. Software fills a 133-bit content register through five 32-bit words, then writes a trigger word that names an operation and an entry index. The block runs the operation against the RAM while a busy flag is raised. Four operations exist: fetch an entry unchanged into the content register, store the content register unchanged, store the data part with check bits generated in hardware, and XOR the content register into an entry in place. The last of these plants single-bit or double-bit faults without changing the content register, so one fault pattern can be applied to many entries in a row.

A normal-traffic port shares the single-ported RAM. Its writes are encoded and its reads are corrected. Maintenance work has fixed priority over this port: while an operation is in flight the port gets no grant. The XOR sequence therefore reads and writes its entry with no foreign access in between. A control bit turns check-bit generation and checking off for the traffic port.

Top module: `dir_ecc_test_port`

## Requirements
- R1: The content register is read and written as words at addresses 0 to 4. Word k holds entry bits 32k+31 down to 32k. Word 4 holds bits 132..128 in its bits 4..0 and reads zero above them. Entry bits 132..125 are the check bits (check bit i at bit 125+i) and bits 124..0 are data.
- R2: A trigger (address 5) with operation code 0 copies all 133 bits of the indexed entry into the content register with no correction. The trigger word holds the code in bits 1..0, the way in bits 7..4 and the index from bit 16 upward.
- R3: Operation code 1 stores all 133 content bits into the indexed entry unchanged, including any check bits software supplied.
- R4: Operation code 2 stores content bits 124..0 as data and replaces the check bits with hardware-generated ones. The data bits occupy, in ascending order, the Hamming positions 3..133 that are not powers of two. Check bit i is the even parity of the data bits whose position has bit i set.
- R5: Operation code 3 writes (entry XOR content) back to the same entry and leaves the content register unchanged.
- R6: A trigger with a nonzero way field runs nothing and sets the sticky way-error flag (status bit 2).
- R7: An accepted trigger raises busy (status bit 1) until its RAM accesses complete. Triggers written while busy are ignored.
- R8: While busy the traffic port gets no grant, so no access falls between the read and the write of an XOR operation. When idle, a request is granted in the same cycle and read data is valid one cycle later.
- R9: With checking on, a traffic-port read corrects a single flipped bit and pulses a corrected flag. A read whose syndrome names a position above 133 pulses an uncorrectable flag. The sticky copies are status bits 3 and 4, and a write of 1 to status bits 2, 3 or 4 clears them.
- R10: Status bit 0 turns checking off. Traffic writes then store zero check bits, and traffic reads return the raw data with no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| np_req | input | 1 | Traffic-port request |
| np_we | input | 1 | Traffic-port write select |
| np_idx | input | IDX_W | Traffic-port entry index |
| np_wdata | input | 125 | Traffic-port write data |
| np_gnt | output | 1 | Request granted this cycle |
| np_rvalid | output | 1 | Read data valid |
| np_rdata | output | 125 | Read data, corrected when checking is on |
| np_corr | output | 1 | Corrected error on this read |
| np_uncorr | output | 1 | Uncorrectable error on this read |

## Verification
The bench builds the block with a depth of 16 entries, so the index field is four bits wide. Random indices then land on the first and the last entry as well as the middle ones. At this size one fault mask can be XORed into several entries and each one read back within a short run. Random data words check the generated check bits against a separately computed code. Directed cases cover a flipped data bit, a flipped check bit, a two-bit pattern whose syndrome falls past position 133, back-to-back triggers, grant hold-off during the XOR sequence, and operation with checking turned off.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
    localparam int DATA_W    = 125;
    localparam int CHK_W     = 8;
    localparam int ENTRY_W   = DATA_W + CHK_W;
    localparam int REG_W     = 32;
    localparam int NWORDS    = (ENTRY_W + REG_W - 1) / REG_W;
    localparam int ADDR_W    = $clog2(NWORDS + 2);
    localparam int TRIG_ADDR = NWORDS;
    localparam int STAT_ADDR = NWORDS + 1;
    localparam int WAY_LSB   = 4;
    localparam int WAY_W     = 4;
    localparam int IDX_LSB   = 16;

    typedef enum logic [1:0] {
        CMD_RD_RAW = 2'd0,
        CMD_WR_RAW = 2'd1,
        CMD_WR_ECC = 2'd2,
        CMD_XOR    = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_CAPT = 2'd2,
        ST_WB   = 2'd3
    } st_e;

    // Hamming check bits: data fills non-power-of-two positions 3..ENTRY_W
    function automatic logic [CHK_W-1:0] ham_check(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        int j;
        c = '0;
        j = 0;
        for (int q = 1; q <= ENTRY_W; q++) begin
            if ((q & (q - 1)) != 0) begin
                for (int i = 0; i < CHK_W; i++) begin
                    if (((q >> i) & 1) != 0) c[i] = c[i] ^ d[j];
                end
                j++;
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/dtp_ecc_enc.sv
module dtp_ecc_enc
    import dtp_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    always_comb begin
        chk = ham_check(data);
    end
endmodule

// File: rtl/dtp_ecc_dec.sv
module dtp_ecc_dec
    import dtp_pkg::*;
(
    input  logic [ENTRY_W-1:0] word,
    output logic [DATA_W-1:0]  data,
    output logic               corr,
    output logic               uncorr
);
    logic [CHK_W-1:0] syn;
    int               j;

    always_comb begin
        syn  = ham_check(word[DATA_W-1:0]) ^ word[ENTRY_W-1:DATA_W];
        data = word[DATA_W-1:0];
        j    = 0;
        for (int q = 1; q <= ENTRY_W; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (syn == CHK_W'(q)) data[j] = ~data[j];
                j++;
            end
        end
        corr   = (syn != '0) && (int'(syn) <= ENTRY_W);
        uncorr = int'(syn) > ENTRY_W;
    end

    // R9: a syndrome is either in range or out of range, never both
    always_comb begin
        p_flag_excl_r9: assert (!(corr && uncorr));
    end
endmodule

// File: rtl/dtp_ram.sv
module dtp_ram #(
    parameter int DEPTH = 32,
    parameter int W     = 133,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata_q
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem_q[idx] <= wdata;
            else    rdata_q    <= mem_q[idx];
        end
    end
endmodule

// File: rtl/dir_ecc_test_port.sv
module dir_ecc_test_port
    import dtp_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic               np_req,
    input  logic               np_we,
    input  logic [IDX_W-1:0]   np_idx,
    input  logic [DATA_W-1:0]  np_wdata,
    output logic               np_gnt,
    output logic               np_rvalid,
    output logic [DATA_W-1:0]  np_rdata,
    output logic               np_corr,
    output logic               np_uncorr
);
    localparam int PAD_W = NWORDS * REG_W;

    typedef struct packed {
        st_e                st;
        cmd_e               cmd;
        logic [IDX_W-1:0]   idx;
        logic [ENTRY_W-1:0] cont;
        logic               ecc_off;
        logic               way_err;
        logic               corr_seen;
        logic               uncorr_seen;
        logic               rd_pend;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               busy;
    logic               trig_hit, stat_hit, cont_hit;
    logic [PAD_W-1:0]   wr_pad, rd_pad;
    logic               ram_en, ram_we;
    logic [IDX_W-1:0]   ram_idx;
    logic [ENTRY_W-1:0] ram_wdata, ram_rdata;
    logic [DATA_W-1:0]  enc_in, dec_data;
    logic [CHK_W-1:0]   enc_chk;
    logic               dec_corr, dec_uncorr;

    assign enc_in = (ctl_q.st == ST_EXEC) ? ctl_q.cont[DATA_W-1:0] : np_wdata;

    dtp_ecc_enc i_enc (.data(enc_in), .chk(enc_chk));

    dtp_ecc_dec i_dec (
        .word   (ram_rdata),
        .data   (dec_data),
        .corr   (dec_corr),
        .uncorr (dec_uncorr)
    );

    dtp_ram #(.DEPTH(DEPTH), .W(ENTRY_W)) i_ram (
        .clk     (clk),
        .en      (ram_en),
        .we      (ram_we),
        .idx     (ram_idx),
        .wdata   (ram_wdata),
        .rdata_q (ram_rdata)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rd_pend = 1'b0;
        busy      = (ctl_q.st != ST_IDLE);
        trig_hit  = cfg_we && (int'(cfg_addr) == TRIG_ADDR);
        stat_hit  = cfg_we && (int'(cfg_addr) == STAT_ADDR);
        cont_hit  = cfg_we && (int'(cfg_addr) < NWORDS);
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_idx   = ctl_q.idx;
        ram_wdata = ctl_q.cont;
        np_gnt    = 1'b0;

        // software access to the content words
        wr_pad = '0;
        wr_pad[ENTRY_W-1:0] = ctl_q.cont;
        if (cont_hit) begin
            wr_pad[int'(cfg_addr)*REG_W +: REG_W] = cfg_wdata;
            ctl_d.cont = wr_pad[ENTRY_W-1:0];
        end

        // control and write-one-to-clear status
        if (stat_hit) begin
            ctl_d.ecc_off = cfg_wdata[0];
            if (cfg_wdata[2]) ctl_d.way_err     = 1'b0;
            if (cfg_wdata[3]) ctl_d.corr_seen   = 1'b0;
            if (cfg_wdata[4]) ctl_d.uncorr_seen = 1'b0;
        end

        // trigger acceptance
        if (trig_hit && !busy) begin
            if (cfg_wdata[WAY_LSB +: WAY_W] != '0) begin
                ctl_d.way_err = 1'b1;
            end else begin
                ctl_d.st  = ST_EXEC;
                ctl_d.cmd = cmd_e'(cfg_wdata[1:0]);
                ctl_d.idx = cfg_wdata[IDX_LSB +: IDX_W];
            end
        end

        // RAM port ownership: maintenance first, traffic only when idle
        case (ctl_q.st)
            ST_IDLE: begin
                if (np_req) begin
                    np_gnt    = 1'b1;
                    ram_en    = 1'b1;
                    ram_we    = np_we;
                    ram_idx   = np_idx;
                    ram_wdata = ctl_q.ecc_off ? {{CHK_W{1'b0}}, np_wdata}
                                              : {enc_chk, np_wdata};
                    ctl_d.rd_pend = !np_we;
                end
            end
            ST_EXEC: begin
                ram_en = 1'b1;
                case (ctl_q.cmd)
                    CMD_RD_RAW: ctl_d.st = ST_CAPT;
                    CMD_WR_RAW: begin
                        ram_we    = 1'b1;
                        ram_wdata = ctl_q.cont;
                        ctl_d.st  = ST_IDLE;
                    end
                    CMD_WR_ECC: begin
                        ram_we    = 1'b1;
                        ram_wdata = {enc_chk, ctl_q.cont[DATA_W-1:0]};
                        ctl_d.st  = ST_IDLE;
                    end
                    default:    ctl_d.st = ST_WB;
                endcase
            end
            ST_CAPT: begin
                ctl_d.cont = ram_rdata;
                ctl_d.st   = ST_IDLE;
            end
            default: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_wdata = ram_rdata ^ ctl_q.cont;
                ctl_d.st  = ST_IDLE;
            end
        endcase

        // sticky error capture on traffic reads
        if (ctl_q.rd_pend && !ctl_q.ecc_off) begin
            if (dec_corr)   ctl_d.corr_seen   = 1'b1;
            if (dec_uncorr) ctl_d.uncorr_seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign np_rvalid = ctl_q.rd_pend;
    assign np_rdata  = ctl_q.ecc_off ? ram_rdata[DATA_W-1:0] : dec_data;
    assign np_corr   = ctl_q.rd_pend && !ctl_q.ecc_off && dec_corr;
    assign np_uncorr = ctl_q.rd_pend && !ctl_q.ecc_off && dec_uncorr;

    always_comb begin
        rd_pad = '0;
        rd_pad[ENTRY_W-1:0] = ctl_q.cont;
        if (int'(cfg_addr) < NWORDS) begin
            cfg_rdata = rd_pad[int'(cfg_addr)*REG_W +: REG_W];
        end else if (int'(cfg_addr) == STAT_ADDR) begin
            cfg_rdata = {{(REG_W-5){1'b0}}, ctl_q.uncorr_seen, ctl_q.corr_seen,
                         ctl_q.way_err, busy, ctl_q.ecc_off};
        end else begin
            cfg_rdata = '0;
        end
    end

    // R5: the write-back hits the entry read one cycle earlier
    p_xor_same_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WB) |-> (ram_we && ram_idx == $past(ram_idx) && $past(ram_en && !ram_we)));

    // R5: the XOR operation never alters the content register
    p_cont_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.cmd == CMD_XOR && !cfg_we) |=> (ctl_q.cont == $past(ctl_q.cont)));

    // R6: a nonzero way is rejected and flagged
    p_way_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !busy && cfg_wdata[WAY_LSB +: WAY_W] != '0) |=> (!busy && ctl_q.way_err));

    // R7: an accepted trigger raises busy; a trigger while busy leaves the target alone
    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !busy && cfg_wdata[WAY_LSB +: WAY_W] == '0) |=> busy);
    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && busy) |=> (ctl_q.idx == $past(ctl_q.idx)));

    // R8: a request made during a maintenance operation returns no data
    p_np_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && np_req) |=> !np_rvalid);
endmodule

// File: tb/test_dir_ecc_test_port.sv
`timescale 1ns/1ps
module test_dir_ecc_test_port;
    localparam int DEPTH = 16;
    localparam int IW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          np_req = 1'b0;
    logic          np_we = 1'b0;
    logic [IW-1:0] np_idx = '0;
    logic [124:0]  np_wdata = '0;
    logic          np_gnt, np_rvalid, np_corr, np_uncorr;
    logic [124:0]  np_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dir_ecc_test_port #(.DEPTH(DEPTH)) i_dir_ecc_test_port (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .np_req(np_req), .np_we(np_we), .np_idx(np_idx), .np_wdata(np_wdata),
        .np_gnt(np_gnt), .np_rvalid(np_rvalid), .np_rdata(np_rdata),
        .np_corr(np_corr), .np_uncorr(np_uncorr)
    );

    function automatic logic [7:0] exp_chk(input logic [124:0] d);
        logic [133:1] cw;
        logic [7:0]   c;
        int           k;
        cw = '0;
        k  = 0;
        for (int p = 1; p <= 133; p++) begin
            if (!(p inside {1, 2, 4, 8, 16, 32, 64, 128})) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int i = 0; i < 8; i++) begin
            logic b;
            b = 1'b0;
            for (int p = 1; p <= 133; p++) if (p[i]) b = b ^ cw[p];
            c[i] = b;
        end
        return c;
    endfunction

    function automatic logic [124:0] rnd_data();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic logic [31:0] trig(input int cmd, input int way, input int idx);
        return (32'(idx) << 16) | (32'(way) << 4) | 32'(cmd);
    endfunction

    task automatic set_cont(input logic [132:0] v);
        logic [159:0] p;
        p = {27'b0, v};
        for (int w = 0; w < 5; w++) reg_wr(3'(w), p[w*32 +: 32]);
    endtask

    task automatic get_cont(output logic [159:0] v);
        logic [31:0] d;
        for (int w = 0; w < 5; w++) begin
            reg_rd(3'(w), d);
            v[w*32 +: 32] = d;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 20; n++) begin
            reg_rd(3'd6, s);
            if (!s[1]) break;
        end
    endtask

    task automatic run(input int cmd, input int idx);
        reg_wr(3'd5, trig(cmd, 0, idx));
        wait_idle();
    endtask

    task automatic np_write(input int idx, input logic [124:0] d);
        @(negedge clk);
        np_req = 1'b1; np_we = 1'b1; np_idx = IW'(idx); np_wdata = d;
        @(negedge clk);
        np_req = 1'b0; np_we = 1'b0;
    endtask

    task automatic np_read(input int idx, output logic [124:0] d, output logic v, output logic c, output logic u);
        @(negedge clk);
        np_req = 1'b1; np_we = 1'b0; np_idx = IW'(idx);
        @(negedge clk);
        np_req = 1'b0;
        #1;
        d = np_rdata; v = np_rvalid; c = np_corr; u = np_uncorr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0]  s;
        logic [159:0] cv;
        logic [124:0] d, dd, e, f, g, h;
        logic         v, c, u;
        logic [132:0] pat;
        void'($urandom(32'h5eed_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        reg_rd(3'd6, s);
        check(s == 32'h0, "R7 reset status", 160'(s), 160'h0);
        get_cont(cv);
        check(cv == '0, "R1 reset content", cv, 160'h0);

        // R1 R2 R3: raw write with arbitrary check bits, raw read back
        pat = {8'hA5, rnd_data()};
        set_cont(pat);
        run(1, 3);
        set_cont('0);
        run(0, 3);
        get_cont(cv);
        check(cv == {27'b0, pat}, "R3 raw write / R2 raw read", cv, {27'b0, pat});
        check(cv[159:133] == '0, "R1 word4 upper bits zero", cv, {27'b0, pat});

        // R4: generated check bits, random data and indices
        for (int n = 0; n < 24; n++) begin
            int idx;
            idx = (n == 0) ? 0 : (n == 1) ? DEPTH - 1 : int'($urandom_range(DEPTH - 1));
            d = rnd_data();
            set_cont({8'h3C, d});
            run(2, idx);
            set_cont('0);
            run(0, idx);
            get_cont(cv);
            check(cv == {27'b0, exp_chk(d), d}, "R4 generated check bits", cv, {27'b0, exp_chk(d), d});
            np_read(idx, dd, v, c, u);
            check(v && dd == d && !c && !u, "R9 clean read", {32'(v), 3'(0), dd}, {32'h1, 3'(0), d});
        end

        // R5 R9: single data-bit fault applied to two entries
        d = rnd_data();
        e = rnd_data();
        set_cont({exp_chk(d), d}); run(1, 5);
        set_cont({exp_chk(e), e}); run(1, 6);
        reg_wr(3'd6, 32'h1C);
        pat = 133'(1) << 40;
        set_cont(pat);
        run(3, 5);
        run(3, 6);
        get_cont(cv);
        check(cv == {27'b0, pat}, "R5 content unchanged", cv, {27'b0, pat});
        np_read(5, dd, v, c, u);
        check(dd == d && c && !u, "R9 single fix entry 5", {29'(c), 3'(u), dd}, {29'h1, 3'h0, d});
        np_read(6, dd, v, c, u);
        check(dd == e && c && !u, "R9 single fix entry 6", {29'(c), 3'(u), dd}, {29'h1, 3'h0, e});
        run(0, 5);
        get_cont(cv);
        check(cv == {27'b0, exp_chk(d), d ^ (125'(1) << 40)}, "R5 xor stored", cv,
              {27'b0, exp_chk(d), d ^ (125'(1) << 40)});
        reg_rd(3'd6, s);
        check(s[4:3] == 2'b01, "R9 sticky corrected", 160'(s), 160'h8);
        reg_wr(3'd6, 32'h1C);
        reg_rd(3'd6, s);
        check(s[4:2] == 3'b000, "R9 write-one clear", 160'(s), 160'h0);

        // R9: check-bit fault
        set_cont({8'h0, 125'(1) << 0} << 125);
        f = rnd_data();
        set_cont({exp_chk(f), f}); run(1, 8);
        set_cont(133'(1) << 125); run(3, 8);
        np_read(8, dd, v, c, u);
        check(dd == f && c && !u, "R9 check-bit fault", {29'(c), 3'(u), dd}, {29'h1, 3'h0, f});

        // R9: double fault with syndrome 3^132 = 135, past position 133
        g = rnd_data();
        set_cont({exp_chk(g), g}); run(1, 7);
        set_cont((133'(1) << 0) | (133'(1) << 123)); run(3, 7);
        np_read(7, dd, v, c, u);
        check(u && !c, "R9 double fault flagged", {158'(0), c, u}, 160'h1);
        reg_rd(3'd6, s);
        check(s[4] == 1'b1, "R9 sticky uncorrectable", 160'(s), 160'h18);
        reg_wr(3'd6, 32'h1C);

        // R6: nonzero way rejected
        f = rnd_data();
        np_write(10, f);
        set_cont({8'h00, ~f});
        reg_wr(3'd5, trig(1, 2, 10));
        reg_rd(3'd6, s);
        check(s[2] == 1'b1 && s[1] == 1'b0, "R6 way error set, not busy", 160'(s), 160'h4);
        np_read(10, dd, v, c, u);
        check(dd == f && !c && !u, "R6 entry untouched", 160'(dd), 160'(f));
        reg_wr(3'd6, 32'h1C);

        // R7: trigger while busy ignored
        g = rnd_data();
        h = rnd_data();
        np_write(11, g);
        set_cont({8'h00, h});
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = trig(2, 0, 12);
        @(negedge clk);
        cfg_wdata = trig(2, 0, 11);
        @(negedge clk);
        cfg_we = 1'b0;
        wait_idle();
        np_read(11, dd, v, c, u);
        check(dd == g && !c, "R7 busy trigger ignored", 160'(dd), 160'(g));
        np_read(12, dd, v, c, u);
        check(dd == h && !c, "R7 first trigger ran", 160'(dd), 160'(h));

        // R7: busy visible during an XOR operation
        set_cont('0);
        reg_wr(3'd5, trig(3, 0, 12));
        #1 check(cfg_addr == 3'd5, "R7 setup", 160'(cfg_addr), 160'h5);
        cfg_addr = 3'd6;
        #1 check(cfg_rdata[1] == 1'b1, "R7 busy raised", 160'(cfg_rdata), 160'h2);
        wait_idle();

        // R8: grant withheld through the XOR sequence
        reg_wr(3'd5, trig(3, 0, 12));
        np_req = 1'b1; np_we = 1'b0; np_idx = IW'(12);
        #1 check(np_gnt == 1'b0, "R8 no grant in read step", 160'(np_gnt), 160'h0);
        @(negedge clk);
        #1 check(np_gnt == 1'b0, "R8 no grant in write step", 160'(np_gnt), 160'h0);
        @(negedge clk);
        #1 check(np_gnt == 1'b1, "R8 grant when idle", 160'(np_gnt), 160'h1);
        @(negedge clk);
        np_req = 1'b0;
        #1 check(np_rvalid && np_rdata == h, "R8 read after release", 160'(np_rdata), 160'(h));

        // R10: checking off
        reg_wr(3'd6, 32'h1);
        e = rnd_data();
        np_write(9, e);
        run(0, 9);
        get_cont(cv);
        check(cv == {27'b0, 8'h00, e}, "R10 zero check bits stored", cv, {27'b0, 8'h00, e});
        set_cont({8'hAB, e ^ 125'h1});
        run(1, 9);
        np_read(9, dd, v, c, u);
        check(v && dd == (e ^ 125'h1) && !c && !u, "R10 raw data, no flags", 160'(dd), 160'(e ^ 125'h1));
        reg_rd(3'd6, s);
        check(s == 32'h1, "R10 no sticky flags", 160'(s), 160'h1);
        reg_wr(3'd6, 32'h0);

        report();
        $finish;
    end
endmodule